// File: doc/BRIEF.md
# Direct-Mapped Block Cache Controller

This block sits between a processor port and a slower main-memory port. The processor issues 15-bit word addresses and reads or writes 12-bit words. The cache holds 512 words, organised as 64 lines of 8 words. Each line keeps one tag, a valid flag and a dirty flag. The address is split as follows:

- bits 14..9 form the tag;
- bits 8..3 select the line;
- bits 2..0 select the word within the line.

A read that finds its tag in the selected line is served from the cache and does not touch memory. A miss refills all eight words of the line before the request is served from the cache.

The parameter `WRITE_BACK` selects the write policy.

- **Write-through (`WRITE_BACK` = 0):** every write goes to memory. A write that misses does not allocate a line.
- **Write-back (`WRITE_BACK` = 1):** a write that hits changes only the cache and marks the line dirty. A write that misses first refills the line and then overwrites the word. A dirty line is copied back to memory before its replacement is fetched.

The processor raises `cpu_req` and holds the command steady until `cpu_ready` pulses for one cycle. While it waits, the processor is stalled. The memory side has a request/acknowledge word interface. The cache holds `mem_req` and the address steady until `mem_ack`. In the acknowledge cycle the memory writes the word, or presents it on `mem_rdata`.

Top module: `dmc_cache`

## Requirements
- R1: After a synchronous active-low reset, all lines are invalid. `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R2: A hit requires the selected line (address bits 8..3) to be valid and to hold a tag equal to address bits 14..9. Any word offset (bits 2..0) of a resident line hits.
- R3: A read hit raises `cpu_ready` in the cycle after the request is first seen, with the cached word on `cpu_rdata`. It makes no memory access.
- R4: A read miss fetches the whole line as 8 memory reads, in offsets 0 to 7. It then returns the requested word to the processor.
- R5: A line whose tag differs from the request is replaced. The evicted block misses again on its next access.
- R6: In write-through mode, a write hit updates both the cache and memory with one memory write. Later reads return the new value, and no line ever becomes dirty.
- R7: In write-through mode, a write miss issues exactly one memory write and does not allocate. A later read of that address misses and refills.
- R8: In write-back mode, a write hit completes in the next cycle with no memory access and marks the line dirty.
- R9: In write-back mode, a miss on a dirty line first writes the 8 victim words back, at the victim's tag, in offsets 0 to 7. The refill follows.
- R10: In write-back mode, a write miss refills the line and then writes the word into the cache, without a memory write.
- R11: In write-back mode, a miss on a clean line does no write-back.
- R12: Each request gets exactly one single-cycle `cpu_ready` pulse. The pulse comes only after all of the request's memory transfers have completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | Word address |
| cpu_wdata | input | 12 | Write data |
| cpu_rdata | output | 12 | Read data, valid with cpu_ready on a read |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory word request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory word completion |

## Verification
Two pieces of work can fall into one miss in write-back mode. One is the copy-back of a dirty victim and the other is the refill of the new block. On the last refill word, the tag update meets the re-examination of the request that the refill was for.

The bench provokes this in three steps:
- it dirties a line with a write hit;
- it then reads a conflicting tag at the same line index;
- it also issues write misses onto dirty lines, plus a long pseudo-random stream over four tags and four line indices.

A behavioural model predicts the exact ordered list of memory transfers, victim data included. Every acknowledged transfer is compared against that list. At each `cpu_ready`, the bench checks that the list is empty and that read data match the latest written value.

// File: rtl/dmc_pkg.sv
// Package dmc_pkg
// Shared type of the direct-mapped cache controller: the controller state.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dmc_pkg;

    // Controller state: idle/lookup, copy-back, refill, single write, respond
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WB   = 3'd1,
        ST_FILL = 3'd2,
        ST_WT   = 3'd3,
        ST_RESP = 3'd4
    } dmc_state_t;

endpackage

// File: rtl/dmc_tag_store.sv
// Module dmc_tag_store
// Per-line tag, valid and dirty storage, read combinationally at one line index.
// A load installs a tag, sets valid and clears dirty. A dirty-set marks the
// indexed line. Valid and dirty clear on a synchronous active-low reset.
// Assumes: load and dirty-set never target the same cycle (the controller
// guarantees this).
module dmc_tag_store #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             load_en,
    input  logic [TAG_W-1:0] load_tag,
    input  logic             dirty_set
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tags [LINES];
    logic [LINES-1:0] valid;
    logic [LINES-1:0] dirty;

    // Per-line state flops, one generate slice per line
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic sel;
        assign sel = (idx == IDX_W'(i));

        // Valid/dirty update for this line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[i] <= 1'b0;
                dirty[i] <= 1'b0;
            end else if (sel && load_en) begin
                valid[i] <= 1'b1;
                dirty[i] <= 1'b0;
            end else if (sel && dirty_set) begin
                dirty[i] <= 1'b1;
            end
        end

        // Tag capture for this line
        always_ff @(posedge clk) begin
            if (sel && load_en) begin
                tags[i] <= load_tag;
            end
        end
    end

    // Combinational read of the indexed line
    assign rd_tag   = tags[idx];
    assign rd_valid = valid[idx];
    assign rd_dirty = dirty[idx];

    // R8
    dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dirty |-> rd_valid);

endmodule

// File: rtl/dmc_data_store.sv
// Module dmc_data_store
// Word array of the cache: one combinational read port, one synchronous
// write port. Holds no reset; a word is only read after it has been written.
// Assumes: the address is {line index, word offset}.
module dmc_data_store #(
    parameter int AW = 9,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    // Word write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Combinational read
    assign rd_data = words[rd_addr];

endmodule

// File: rtl/dmc_ctrl.sv
// Module dmc_ctrl
// Cache controller state machine.
// - Looks up the request.
// - Sequences the dirty-line copy-back and the line refill word by word.
// - Issues write-through writes.
// - Pulses cpu_ready once per request.
// After a refill it returns to lookup, so the request is served from the
// cache as a hit.
// Assumes: the processor holds cpu_req, cpu_we, cpu_addr and cpu_wdata
// stable until cpu_ready; memory holds mem_ack for one cycle per word.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 12,
    parameter int IDX_W      = 6,
    parameter int OFF_W      = 3,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    cpu_ready,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic                    mem_ack,
    input  logic [ADDR_W-IDX_W-OFF_W-1:0] rd_tag,
    input  logic                    rd_valid,
    input  logic                    rd_dirty,
    output logic                    load_en,
    output logic [ADDR_W-IDX_W-OFF_W-1:0] load_tag,
    output logic                    dirty_set,
    output logic [IDX_W+OFF_W-1:0]  d_rd_addr,
    input  logic [DATA_W-1:0]       d_rd_data,
    output logic                    d_wr_en,
    output logic [IDX_W+OFF_W-1:0]  d_wr_addr,
    output logic [DATA_W-1:0]       d_wr_data
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST = {OFF_W{1'b1}};

    dmc_state_t       state, state_d;
    logic [OFF_W-1:0] cnt, cnt_d;

    logic [TAG_W-1:0] cpu_tag;
    logic [IDX_W-1:0] cpu_idx;
    logic [OFF_W-1:0] cpu_off;
    logic             hit;
    logic             look;
    logic             idle_wr_hit;
    logic             idle_rd_hit;
    logic             fill_ack;

    // Address fields and hit detection
    assign cpu_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_idx     = cpu_addr[OFF_W +: IDX_W];
    assign cpu_off     = cpu_addr[OFF_W-1:0];
    assign hit         = rd_valid && (rd_tag == cpu_tag);
    assign look        = (state == ST_IDLE) && cpu_req;
    assign idle_wr_hit = look && hit && cpu_we;
    assign idle_rd_hit = look && hit && !cpu_we;
    assign fill_ack    = (state == ST_FILL) && mem_ack;

    // Next-state and word-counter decision
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        case (state)
            ST_IDLE: begin
                cnt_d = '0;
                if (cpu_req) begin
                    if (hit) begin
                        if (!cpu_we || WRITE_BACK) state_d = ST_RESP;
                        else                       state_d = ST_WT;
                    end else if (cpu_we && !WRITE_BACK) begin
                        state_d = ST_WT;
                    end else if (WRITE_BACK && rd_valid && rd_dirty) begin
                        state_d = ST_WB;
                    end else begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_WB: begin
                if (mem_ack) begin
                    cnt_d = cnt + 1'b1;
                    if (cnt == LAST) state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    cnt_d = cnt + 1'b1;
                    if (cnt == LAST) state_d = ST_IDLE;
                end
            end
            ST_WT: begin
                if (mem_ack) state_d = ST_RESP;
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    // Read data capture on a read hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (idle_rd_hit) begin
            cpu_rdata <= d_rd_data;
        end
    end

    // Processor completion
    assign cpu_ready = (state == ST_RESP);

    // Tag store control
    assign load_en   = fill_ack && (cnt == LAST);
    assign load_tag  = cpu_tag;
    assign dirty_set = WRITE_BACK && idle_wr_hit;

    // Data store port steering
    assign d_rd_addr = (state == ST_WB) ? {cpu_idx, cnt} : {cpu_idx, cpu_off};
    assign d_wr_en   = idle_wr_hit || fill_ack;
    assign d_wr_addr = fill_ack ? {cpu_idx, cnt} : {cpu_idx, cpu_off};
    assign d_wr_data = fill_ack ? mem_rdata : cpu_wdata;

    // Memory port steering
    assign mem_req   = (state == ST_WB) || (state == ST_FILL) || (state == ST_WT);
    assign mem_we    = (state == ST_WB) || (state == ST_WT);
    assign mem_addr  = (state == ST_WB)   ? {rd_tag, cpu_idx, cnt} :
                       (state == ST_FILL) ? {cpu_tag, cpu_idx, cnt} : cpu_addr;
    assign mem_wdata = (state == ST_WB) ? d_rd_data : cpu_wdata;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !cpu_ready));

    // R3
    read_hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_rd_hit |=> (cpu_ready && !mem_req));

    // R12
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R4
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9
    wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WB) && mem_ack && (cnt != LAST)) |=>
            ((state == ST_WB) && (cnt == $past(cnt) + 1'b1)));

    // R6
    if (!WRITE_BACK) begin : g_wt_chk
        wt_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_dirty);
    end

endmodule

// File: rtl/dmc_cache.sv
// Module dmc_cache
// Direct-mapped block cache: tag store, data store and controller.
// The address splits into tag, line index and word offset. WRITE_BACK
// selects write-back with dirty lines (1) or write-through without
// write allocation (0).
// Assumes: the processor holds its command until cpu_ready; memory
// acknowledges each word with a one-cycle mem_ack.
module dmc_cache #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 12,
    parameter int IDX_W      = 6,
    parameter int OFF_W      = 3,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int LW_W  = IDX_W + OFF_W;

    logic [TAG_W-1:0]  rd_tag, load_tag;
    logic              rd_valid, rd_dirty, load_en, dirty_set;
    logic [LW_W-1:0]   d_rd_addr, d_wr_addr;
    logic [DATA_W-1:0] d_rd_data, d_wr_data;
    logic              d_wr_en;

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (cpu_addr[OFF_W +: IDX_W]),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .load_en  (load_en),
        .load_tag (load_tag),
        .dirty_set(dirty_set)
    );

    dmc_data_store #(.AW(LW_W), .DW(DATA_W)) u_data (
        .clk    (clk),
        .rd_addr(d_rd_addr),
        .rd_data(d_rd_data),
        .wr_en  (d_wr_en),
        .wr_addr(d_wr_addr),
        .wr_data(d_wr_data)
    );

    dmc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .OFF_W(OFF_W), .WRITE_BACK(WRITE_BACK)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .mem_ack  (mem_ack),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .load_en  (load_en),
        .load_tag (load_tag),
        .dirty_set(dirty_set),
        .d_rd_addr(d_rd_addr),
        .d_rd_data(d_rd_data),
        .d_wr_en  (d_wr_en),
        .d_wr_addr(d_wr_addr),
        .d_wr_data(d_wr_data)
    );

endmodule

// File: tb/dmc_cache_tb_top.sv
// Bench environment
// One cache instance with a behavioural memory and a behavioural
// reference model. The model predicts the ordered memory transfers and
// the read data of each request; every acknowledged transfer and every
// completion is compared against it.
module dmc_cache_env #(
    parameter bit WB  = 1'b1,
    parameter int LAT = 1
) (
    input  logic clk,
    output logic done,
    output int   n_chk,
    output int   n_err
);
    logic        rst_n;
    logic        cpu_req, cpu_we, cpu_ready, mem_req, mem_we, mem_ack;
    logic [14:0] cpu_addr, mem_addr;
    logic [11:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;

    dmc_cache #(.WRITE_BACK(WB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    logic [11:0] smem [int];
    logic [11:0] arch [int];
    logic [27:0] exp_q [$];
    bit          rv  [64];
    logic [5:0]  rt  [64];
    bit          rdt [64];
    string       cur_tag = "R1";
    int          wcnt;

    function automatic logic [11:0] init_val(input int a);
        return 12'((a * 37) ^ 12'h5C3);
    endfunction

    function automatic logic [11:0] smem_rd(input int a);
        return smem.exists(a) ? smem[a] : init_val(a);
    endfunction

    function automatic logic [11:0] arch_rd(input int a);
        return arch.exists(a) ? arch[a] : init_val(a);
    endfunction

    function automatic logic [14:0] mk(input int tg, input int ix, input int o);
        return {6'(tg), 6'(ix), 3'(o)};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Memory model: acknowledges after LAT waiting cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req) begin
            if (wcnt >= LAT) begin
                mem_ack <= 1'b1;
                if (mem_we) smem[int'(mem_addr)] = mem_wdata;
                else        mem_rdata <= smem_rd(int'(mem_addr));
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // Transfer monitor: each acknowledged word against the prediction
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            logic [27:0] got;
            got = {mem_we, mem_addr, mem_we ? mem_wdata : 12'h0};
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected memory transfer", int'(got), 0);
            end else begin
                logic [27:0] e;
                e = exp_q.pop_front();
                chk(got == e, cur_tag, "memory transfer {we,addr,data}", int'(got), int'(e));
            end
        end
    end

    // One processor request with prediction and completion checks
    task automatic do_op(input bit we, input logic [14:0] a, input logic [11:0] d,
                         input string tag);
        int         ix;
        logic [5:0] tg;
        bit         hit, fast;
        int         cyc;
        ix      = int'(a[8:3]);
        tg      = a[14:9];
        cur_tag = tag;
        hit     = rv[ix] && (rt[ix] == tg);
        fast    = hit && (!we || WB);
        if (we && !WB) begin
            exp_q.push_back({1'b1, a, d});
        end else if (!hit) begin
            if (WB && rv[ix] && rdt[ix]) begin
                for (int o = 0; o < 8; o++) begin
                    logic [14:0] va;
                    va = {rt[ix], 6'(ix), 3'(o)};
                    exp_q.push_back({1'b1, va, arch_rd(int'(va))});
                end
            end
            for (int o = 0; o < 8; o++) begin
                exp_q.push_back({1'b0, tg, 6'(ix), 3'(o), 12'h0});
            end
            rv[ix]  = 1'b1;
            rt[ix]  = tg;
            rdt[ix] = 1'b0;
        end
        if (we) begin
            arch[int'(a)] = d;
            if (WB) rdt[ix] = 1'b1;
        end
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_req   = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 5000);
        chk(cyc < 5000, tag, "request timed out", cyc, 0);
        chk(exp_q.size() == 0, tag, "transfers left at ready (R12)", exp_q.size(), 0);
        exp_q.delete();
        if (fast) chk(cyc == 1, tag, "hit latency (R3/R8)", cyc, 1);
        if (!we)  chk(cpu_rdata == arch_rd(int'(a)), tag, "read data",
                      int'(cpu_rdata), int'(arch_rd(int'(a))));
        cpu_req = 1'b0;
        @(negedge clk);
        chk(!cpu_ready, tag, "ready pulse length (R12)", int'(cpu_ready), 0);
    endtask

    // Stimulus
    initial begin
        int s;
        done = 1'b0; n_chk = 0; n_err = 0;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin rv[i] = 1'b0; rt[i] = '0; rdt[i] = 1'b0; end
        repeat (3) @(negedge clk);
        // R1: quiet ports during reset
        chk(!mem_req && !cpu_ready, "R1", "reset outputs", int'({mem_req, cpu_ready}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !cpu_ready, "R1", "idle after reset", int'({mem_req, cpu_ready}), 0);
        do_op(1'b0, mk(0, 40, 0), 12'h0, "R1");
        do_op(1'b0, mk(1, 5, 3), 12'h0, "R4");
        do_op(1'b0, mk(1, 5, 6), 12'h0, "R2");
        do_op(1'b0, mk(1, 5, 0), 12'h0, "R3");
        do_op(1'b0, mk(2, 5, 1), 12'h0, "R5");
        do_op(1'b0, mk(1, 5, 3), 12'h0, "R5");
        if (WB) begin
            do_op(1'b1, mk(1, 5, 2), 12'hABC, "R8");
            do_op(1'b0, mk(1, 5, 2), 12'h0, "R8");
            chk(smem_rd(int'(mk(1, 5, 2))) != 12'hABC, "R8", "memory untouched by write hit",
                int'(smem_rd(int'(mk(1, 5, 2)))), int'(init_val(int'(mk(1, 5, 2)))));
            do_op(1'b0, mk(3, 5, 0), 12'h0, "R9");
            chk(smem_rd(int'(mk(1, 5, 2))) == 12'hABC, "R9", "victim word in memory",
                int'(smem_rd(int'(mk(1, 5, 2)))), 12'hABC);
            do_op(1'b1, mk(4, 9, 7), 12'h123, "R10");
            do_op(1'b0, mk(4, 9, 7), 12'h0, "R10");
            do_op(1'b0, mk(5, 9, 0), 12'h0, "R9");
            do_op(1'b0, mk(6, 9, 0), 12'h0, "R11");
        end else begin
            do_op(1'b1, mk(1, 5, 2), 12'hABC, "R6");
            chk(smem_rd(int'(mk(1, 5, 2))) == 12'hABC, "R6", "memory updated",
                int'(smem_rd(int'(mk(1, 5, 2)))), 12'hABC);
            do_op(1'b0, mk(1, 5, 2), 12'h0, "R6");
            do_op(1'b1, mk(7, 20, 4), 12'h5A5, "R7");
            chk(smem_rd(int'(mk(7, 20, 4))) == 12'h5A5, "R7", "memory updated on miss",
                int'(smem_rd(int'(mk(7, 20, 4)))), 12'h5A5);
            do_op(1'b0, mk(7, 20, 4), 12'h0, "R7");
            do_op(1'b0, mk(8, 5, 0), 12'h0, "R6");
        end
        s = WB ? 7 : 11;
        for (int i = 0; i < 150; i++) begin
            logic [14:0] a;
            s = s * 1103515245 + 12345;
            a = {4'b0, s[20:19], 4'b0, s[22:21], s[25:23]};
            do_op(s[26], a, s[11:0], "R12");
        end
        done = 1'b1;
    end
endmodule

// Bench top: two environments, one per write policy, sharing a 100 MHz clock
module dmc_cache_tb_top;
    logic clk = 1'b0;
    logic done_wb, done_wt;
    int   c_wb, e_wb, c_wt, e_wt;

    always #5 clk = ~clk;

    dmc_cache_env #(.WB(1'b1), .LAT(1)) u_env_wb (.clk(clk), .done(done_wb), .n_chk(c_wb), .n_err(e_wb));
    dmc_cache_env #(.WB(1'b0), .LAT(2)) u_env_wt (.clk(clk), .done(done_wt), .n_chk(c_wt), .n_err(e_wt));

    // Completion wait with watchdog, then the summary
    initial begin
        int wd_err;
        int wd_chk;
        wd_err = 0;
        wd_chk = 1;
        fork
            wait (done_wb === 1'b1 && done_wt === 1'b1);
            repeat (190000) @(posedge clk);
        join_any
        if (!(done_wb === 1'b1 && done_wt === 1'b1)) begin
            wd_err = 1;
            $display("FAIL R12 watchdog: actual=%0d expected=%0d", 0, 1);
        end
        $display("  Result: errors=%0d of %0d checks", e_wb + e_wt + wd_err, c_wb + c_wt + wd_chk);
        $finish;
    end
endmodule